// File: doc/BRIEF.md
# Fetch Direction and Target Predictor

This block sits beside the fetch stage of a 32-bit pipeline whose instructions are one aligned word each. Every cycle it takes the current fetch address and answers three questions without waiting for a clock edge. It reports whether the target cache holds an entry for that address, and whether the direction counter for that address leans towards taken. It also gives the address to fetch next. When the cache holds an entry and the counter leans towards taken, the next address is the cached target, so fetch moves to the branch target in the same cycle. In every other case it is the word that follows.

Two direct-mapped tables hold the state. The first is a set of two-bit saturating counters. A single wrong outcome only weakens a strong counter; the predicted direction changes after two wrong outcomes in a row. The second is a target cache. Each entry holds a valid flag, an address tag and a target. The pipeline drives the update port once a branch resolves. It gives the real direction and target, together with the prediction that was made for that branch at fetch time. The block trains the counter, installs the target when the branch was taken, and raises a mispredict flag in the same cycle so the pipeline can flush.

Top module: `fetch_predictor`

## Requirements
- R1: After reset every counter holds 01 and every target entry is invalid, so any lookup gives hit 0, taken 0 and next address PC+4.
- R2: An address selects its entry with bits [IDX_W+1:2] (IDX_W = log2 DEPTH) and its tag is bits [31:IDX_W+2]. Two addresses that differ only in bit 2 use separate counters.
- R3: Counter values 00 and 01 predict not taken, and 10 and 11 predict taken. A taken update adds one and a not-taken update subtracts one. The counter stays at 11 when incremented and at 00 when decremented.
- R4: From 11, one not-taken update leaves the prediction taken. From 00, one taken update leaves it not taken.
- R5: The next fetch address is the stored target when the lookup hits and predicts taken. Otherwise it is PC+4, and this includes a hit that predicts not taken.
- R6: A taken update writes the tag and the target into its entry and marks the entry valid. A not-taken update leaves the target cache unchanged.
- R7: A lookup hits only when the entry is valid and its stored tag equals the tag of the lookup address. An address that shares the index but has another tag misses, and it still sees the shared counter.
- R8: up_mispredict is 1 when up_valid is set and either the resolved direction differs from up_pred_taken, or the branch is taken and up_pred_next differs from up_target. It is 0 in every other case, and it is combinational on the update inputs.
- R9: An update changes state at the clock edge. A lookup in the same cycle sees the state from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | 32 | Fetch address being looked up |
| lk_hit | output | 1 | Target cache holds a valid entry with a matching tag |
| lk_taken | output | 1 | Direction counter predicts taken |
| lk_next | output | 32 | Predicted next fetch address |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_pc | input | 32 | Address of the resolved branch |
| up_taken | input | 1 | Resolved direction |
| up_target | input | 32 | Resolved target address |
| up_pred_taken | input | 1 | Direction predicted for this branch at fetch |
| up_pred_next | input | 32 | Next address predicted for this branch at fetch |
| up_mispredict | output | 1 | Prediction was wrong; flush needed |

## Verification
The bench targets hysteresis. A loop branch trained to strongly taken sees one not-taken exit and must still predict taken. A design that flips at once would mispredict on the next loop entry. The bench drives both counters to their limits and pushes further, where a counter that wraps would jump from strongly taken to strongly not taken. It looks up an aliasing address that shares an index but has another tag; a design that skips the tag compare would send fetch to a foreign target. It also checks that a not-taken update installs nothing, and that a correct direction with a wrong target still raises mispredict. Updates and lookups to the same entry fall in the same cycle, which exposes a design that bypasses the new state into the lookup.

// File: rtl/fp_pkg.sv
package fp_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_e;

    // Saturating step of a two-bit direction counter.
    function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
        logic [1:0] nxt;
        if (taken) nxt = (cur == CTR_STRONG_T)  ? cur : cur + 2'd1;
        else       nxt = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
        return nxt;
    endfunction

endpackage

// File: rtl/fp_dir_table.sv
module fp_dir_table #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    import fp_pkg::*;

    typedef struct packed {
        logic [DEPTH-1:0][1:0] ctr;
    } dir_state_t;

    dir_state_t st_d, st_q;
    logic [DEPTH-1:0][1:0] step_d;

    // One saturating stepper per entry.
    for (genvar g = 0; g < DEPTH; g++) begin : g_step
        assign step_d[g] = ctr_step(st_q.ctr[g], wr_taken);
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.ctr[wr_idx] = step_d[wr_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.ctr <= {DEPTH{CTR_WEAK_NT}};
        else        st_q     <= st_d;
    end

    assign rd_taken = st_q.ctr[rd_idx][1];

    // R3: no wrap past the top of the counter
    a_r3_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_taken && st_q.ctr[wr_idx] == CTR_STRONG_T
        |=> st_q.ctr[$past(wr_idx)] == CTR_STRONG_T);

    // R3: no wrap past the bottom of the counter
    a_r3_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_taken && st_q.ctr[wr_idx] == CTR_STRONG_NT
        |=> st_q.ctr[$past(wr_idx)] == CTR_STRONG_NT);

    // R4: a single opposite outcome does not flip a strong prediction
    a_r4_hysteresis: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_taken && st_q.ctr[wr_idx] == CTR_STRONG_T
        |=> st_q.ctr[$past(wr_idx)][1]);

endmodule

// File: rtl/fp_target_buf.sv
module fp_target_buf #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int TAG_W = ADDR_W - 2 - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              rd_hit,
    output logic [ADDR_W-1:0] rd_target,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_target
);
    typedef struct packed {
        logic [DEPTH-1:0]             valid;
        logic [DEPTH-1:0][TAG_W-1:0]  tag;
        logic [DEPTH-1:0][ADDR_W-1:0] tgt;
    } tb_state_t;

    tb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.valid[wr_idx] = 1'b1;
            st_d.tag[wr_idx]   = wr_tag;
            st_d.tgt[wr_idx]   = wr_target;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.valid <= '0;
            st_q.tag   <= '0;
            st_q.tgt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_hit    = st_q.valid[rd_idx] && (st_q.tag[rd_idx] == rd_tag);
    assign rd_target = st_q.tgt[rd_idx];

    // R6: an install leaves a valid entry carrying the written tag and target
    a_r6_install: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> st_q.valid[$past(wr_idx)]
              && st_q.tag[$past(wr_idx)] == $past(wr_tag)
              && st_q.tgt[$past(wr_idx)] == $past(wr_target));

    // R6: entries change only when written
    a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q));

endmodule

// File: rtl/fetch_predictor.sv
module fetch_predictor #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int TAG_W = ADDR_W - 2 - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_pc,
    output logic              lk_hit,
    output logic              lk_taken,
    output logic [ADDR_W-1:0] lk_next,
    input  logic              up_valid,
    input  logic [ADDR_W-1:0] up_pc,
    input  logic              up_taken,
    input  logic [ADDR_W-1:0] up_target,
    input  logic              up_pred_taken,
    input  logic [ADDR_W-1:0] up_pred_next,
    output logic              up_mispredict
);
    logic [IDX_W-1:0]  lk_idx, up_idx;
    logic [TAG_W-1:0]  lk_tag, up_tag;
    logic [ADDR_W-1:0] cached_tgt;
    logic              up_pc_unused;

    assign lk_idx       = lk_pc[IDX_W+1:2];
    assign lk_tag       = lk_pc[ADDR_W-1 -: TAG_W];
    assign up_idx       = up_pc[IDX_W+1:2];
    assign up_tag       = up_pc[ADDR_W-1 -: TAG_W];
    assign up_pc_unused = ^up_pc[1:0];

    fp_dir_table #(.DEPTH(DEPTH)) u_dir (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_idx),
        .rd_taken (lk_taken),
        .wr_en    (up_valid),
        .wr_idx   (up_idx),
        .wr_taken (up_taken)
    );

    fp_target_buf #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_tgt (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (lk_idx),
        .rd_tag    (lk_tag),
        .rd_hit    (lk_hit),
        .rd_target (cached_tgt),
        .wr_en     (up_valid && up_taken),
        .wr_idx    (up_idx),
        .wr_tag    (up_tag),
        .wr_target (up_target)
    );

    always_comb begin
        lk_next = lk_pc + ADDR_W'(4);
        if (lk_hit && lk_taken) lk_next = cached_tgt;
    end

    always_comb begin
        up_mispredict = 1'b0;
        if (up_valid) begin
            if (up_pred_taken != up_taken)                  up_mispredict = 1'b1;
            else if (up_taken && up_pred_next != up_target) up_mispredict = 1'b1;
        end
    end

    // R8: a fully correct prediction never requests a flush
    a_r8_agree: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid && up_pred_taken == up_taken && (!up_taken || up_pred_next == up_target)
        |-> !up_mispredict);

    // R5: fetch leaves the sequential path only on a taken hit
    a_r5_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        lk_next != lk_pc + ADDR_W'(4) |-> lk_hit && lk_taken);

endmodule

// File: tb/fetch_predictor_bench.sv
module fetch_predictor_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        lk_hit, lk_taken, up_mispredict;
    logic [31:0] lk_next;
    logic        up_valid = 1'b0;
    logic [31:0] up_pc = '0;
    logic        up_taken = 1'b0;
    logic [31:0] up_target = '0;
    logic        up_pred_taken = 1'b0;
    logic [31:0] up_pred_next = '0;

    int checks = 0;
    int errors = 0;

    // behavioural model
    int          m_ctr   [DEPTH];
    bit          m_valid [DEPTH];
    logic [31:0] m_tag   [DEPTH];
    logic [31:0] m_tgt   [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    fetch_predictor #(.DEPTH(DEPTH)) u_fetch_predictor (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_taken(lk_taken),
        .lk_next(lk_next), .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
        .up_target(up_target), .up_pred_taken(up_pred_taken), .up_pred_next(up_pred_next),
        .up_mispredict(up_mispredict)
    );

    function automatic int idx_of(logic [31:0] a);
        return int'((a >> 2) % DEPTH);
    endfunction

    function automatic logic [31:0] tag_of(logic [31:0] a);
        return a >> (2 + $clog2(DEPTH));
    endfunction

    function automatic bit m_pred(logic [31:0] a);
        return m_ctr[idx_of(a)] >= 2;
    endfunction

    function automatic logic [31:0] m_next(logic [31:0] a);
        int i = idx_of(a);
        if (m_valid[i] && m_tag[i] == tag_of(a) && m_ctr[i] >= 2) return m_tgt[i];
        return a + 32'd4;
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) begin
            m_ctr[i] = 1; m_valid[i] = 0; m_tag[i] = '0; m_tgt[i] = '0;
        end
    endtask

    // One cycle: drive, compare before the edge against the old model state, then advance the model.
    task automatic step(string req, logic [31:0] pc, bit uv, logic [31:0] upc, bit ut,
                        logic [31:0] utgt, bit upt, logic [31:0] upn);
        int i, e_hit;
        bit e_mis;
        @(negedge clk);
        lk_pc = pc; up_valid = uv; up_pc = upc; up_taken = ut;
        up_target = utgt; up_pred_taken = upt; up_pred_next = upn;
        #1;
        i = idx_of(pc);
        e_hit = (m_valid[i] && m_tag[i] == tag_of(pc)) ? 1 : 0;
        e_mis = uv && ((upt != ut) || (ut && upn != utgt));
        check(req, "lk_hit", {31'd0, lk_hit}, e_hit);
        check(req, "lk_taken", {31'd0, lk_taken}, {31'd0, m_pred(pc)});
        check(req, "lk_next", lk_next, m_next(pc));
        check(req, "up_mispredict", {31'd0, up_mispredict}, {31'd0, e_mis});
        if (uv) begin
            int j = idx_of(upc);
            if (ut) begin
                if (m_ctr[j] < 3) m_ctr[j]++;
                m_valid[j] = 1; m_tag[j] = tag_of(upc); m_tgt[j] = utgt;
            end else if (m_ctr[j] > 0) begin
                m_ctr[j]--;
            end
        end
    endtask

    task automatic look(string req, logic [31:0] pc);
        step(req, pc, 0, '0, 0, '0, 0, '0);
    endtask

    task automatic train(string req, logic [31:0] pc, bit ut, logic [31:0] tgt);
        step(req, pc, 1, pc, ut, tgt, m_pred(pc), m_next(pc));
    endtask

    localparam logic [31:0] BR_A  = 32'h0000_1008;
    localparam logic [31:0] TGT_A = 32'h0000_2000;
    localparam logic [31:0] BR_B  = 32'h0000_300C;
    localparam logic [31:0] ALIAS = BR_A + 32'(DEPTH*4);

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int k = 0; k < 4; k++) look("R1", 32'h100 + 32'(k*4));

        // R8 first taken resolution with fall-through prediction
        step("R8", BR_A, 1, BR_A, 1, TGT_A, 0, BR_A + 4);
        // R5 R6 taken hit redirects fetch
        look("R5", BR_A);
        look("R6", BR_A);
        train("R3", BR_A, 1, TGT_A);
        // R4 loop exit once, next entry still taken
        train("R4", BR_A, 0, BR_A + 4);
        look("R4", BR_A);
        train("R4", BR_A, 1, TGT_A);
        // R3 saturate high then walk down to the bottom
        repeat (3) train("R3", BR_A, 1, TGT_A);
        repeat (5) train("R3", BR_A, 0, BR_A + 4);
        // R5 hit but not taken falls through
        look("R5", BR_A);
        // R4 from strong not taken, one taken stays not taken
        train("R4", BR_A, 1, TGT_A);
        look("R4", BR_A);
        // R7 aliasing address shares the counter but misses
        repeat (2) train("R7", BR_A, 1, TGT_A);
        look("R7", ALIAS);
        // R2 neighbour word uses its own counter
        look("R2", BR_A + 4);
        // R6 not-taken update installs nothing
        train("R6", BR_B, 0, BR_B + 4);
        look("R6", BR_B);
        // R8 right direction, wrong target, then right target
        step("R8", BR_A, 1, BR_A, 1, TGT_A, 1, 32'h0000_4444);
        step("R8", BR_A, 1, BR_A, 1, TGT_A, 1, TGT_A);
        step("R8", BR_A, 1, BR_A, 0, TGT_A, 0, 32'h0000_5555);
        // R9 same-cycle lookup sees old state
        step("R9", BR_B, 1, BR_B, 1, 32'h0000_6000, 0, BR_B + 4);
        look("R9", BR_B);

        // mixed traffic
        for (int n = 0; n < 400; n++) begin
            logic [31:0] pcs[4] = '{BR_A, BR_B, ALIAS, 32'h0000_2010};
            logic [31:0] p = pcs[$urandom_range(0, 3)];
            logic [31:0] u = pcs[$urandom_range(0, 3)];
            logic [31:0] t = 32'h0000_8000 + 32'($urandom_range(0, 3) * 16);
            bit v = ($urandom_range(0, 3) != 0);
            bit d = $urandom_range(0, 1) == 1;
            step("R9", p, v, u, d, t, m_pred(u), m_next(u));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL R9 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule